// File: doc/BRIEF.md
# Interrupt Mask and Priority Controller

This block gathers 64 interrupt request lines into one prioritised request. Software never reads and rewrites the 64-bit mask. It writes one byte to a set port to mask one source, or one byte to a clear port to unmask one source. The reserved code 0xFF on either port acts on all sources at once. Each source also has a small level register, and a level of zero keeps that source silent.

On every clock the controller picks the winner among the sources that are pending, unmasked and at a non-zero level. The highest level wins, and on equal levels the lowest source index wins. It registers the winner's index and level on `req_vec` and `req_lvl`, with `req_valid` high. When no source qualifies, all three outputs are zero.

Top module: `intr_mask_ctrl`

## Requirements
- R1: After reset all 64 mask bits are set, all levels are 0, and `req_valid`, `req_vec` and `req_lvl` are 0.
- R2: A write of index 0..63 on the set port (`set_wr` high, index on `set_idx`) masks that source. Other sources are not affected.
- R3: A write of index 0..63 on the clear port (`clr_wr` high, index on `clr_idx`) unmasks that source. Other sources are not affected.
- R4: The code 0xFF on the set port masks all 64 sources in one write.
- R5: The code 0xFF on the clear port unmasks all 64 sources in one write.
- R6: Index values 64 to 254 on either port change no mask bit.
- R7: When both ports are written in the same cycle, the clear is applied first and the set second. A source named by both, or covered by a set of 0xFF, ends up masked. Writes to different bits both take effect.
- R8: A write with `lvl_wr` high stores `lvl_data` as the level of source `lvl_sel`. A source at level 0 is never requested.
- R9: Among the pending (`irq_pend` bit high), unmasked, non-zero-level sources, the one with the highest level is output on `req_vec` with its level on `req_lvl`.
- R10: When several qualifying sources share the highest level, the lowest source index wins.
- R11: When no source qualifies, `req_valid` is 0 and `req_vec` and `req_lvl` are 0.
- R12: The outputs are registered. A change of `irq_pend` shows one clock edge later. A mask or level write shows two clock edges after the write is presented: one edge to store the write, one to register the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_wr | input | 1 | Set-port write strobe |
| set_idx | input | 8 | Source index to mask, or 0xFF for all |
| clr_wr | input | 1 | Clear-port write strobe |
| clr_idx | input | 8 | Source index to unmask, or 0xFF for all |
| lvl_wr | input | 1 | Level write strobe |
| lvl_sel | input | 6 | Source whose level is written |
| lvl_data | input | 3 | New level value |
| irq_pend | input | 64 | Pending request lines, one per source |
| req_valid | output | 1 | A qualifying source exists |
| req_vec | output | 6 | Index of the winning source |
| req_lvl | output | 3 | Level of the winning source |

## Verification
The bench targets the edges of the byte code space. It writes indices 64, 100, 200 and 254, which a design that decodes only the low six bits would turn into real mask changes. It writes 0xFF, which such a design would treat as source 63 instead of all sources. It writes both ports in the same cycle, where the wrong precedence would leave a source enabled that should be masked. It builds level ties at both low and high indices, where a tree that favours the wrong child would report the higher index. It then checks level-zero sources, which a design that looks only at pending and mask would grant. Finally it samples one cycle after a change of pending, where a combinational output or an extra pipeline stage would show up as the wrong value.

// File: rtl/intm_pkg.sv
package intm_pkg;
    localparam int NSRC   = 64;
    localparam int IDXW   = $clog2(NSRC);
    localparam int LVLW   = 3;
    localparam int CODEW  = 8;
    localparam logic [CODEW-1:0] ALL_CODE = '1;
    localparam logic [CODEW-1:0] SRC_LIM  = CODEW'(NSRC);

    typedef struct packed {
        logic            valid;
        logic [LVLW-1:0] lvl;
        logic [IDXW-1:0] idx;
    } cand_t;

    // lo covers lower indices, so it keeps equal levels
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        cand_t r;
        if (!lo.valid)
            r = hi;
        else if (!hi.valid)
            r = lo;
        else if (hi.lvl > lo.lvl)
            r = hi;
        else
            r = lo;
        return r;
    endfunction
endpackage

// File: rtl/intm_mask.sv
module intm_mask
    import intm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic [CODEW-1:0] set_idx,
    input  logic             clr_wr,
    input  logic [CODEW-1:0] clr_idx,
    output logic [NSRC-1:0]  mask_o
);
    typedef struct packed {
        logic [NSRC-1:0] mask;
    } mstate_t;

    mstate_t st_d, st_q;
    logic [NSRC-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (set_wr) begin
            if (set_idx == ALL_CODE)
                set_vec = '1;
            else if (set_idx < SRC_LIM)
                set_vec[set_idx[IDXW-1:0]] = 1'b1;
        end
        if (clr_wr) begin
            if (clr_idx == ALL_CODE)
                clr_vec = '1;
            else if (clr_idx < SRC_LIM)
                clr_vec[clr_idx[IDXW-1:0]] = 1'b1;
        end
        st_d.mask = (st_q.mask & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.mask <= '1;
        else
            st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    AST_SET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && set_idx < SRC_LIM) |=> mask_o[$past(set_idx[IDXW-1:0])]); // R2
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_idx < SRC_LIM && !set_wr) |=> !mask_o[$past(clr_idx[IDXW-1:0])]); // R3
    AST_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && set_idx == ALL_CODE) |=> (&mask_o)); // R4
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_idx == ALL_CODE && !set_wr) |=> (mask_o == '0)); // R5
    AST_IGNORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!set_wr || (set_idx >= SRC_LIM && set_idx != ALL_CODE)) &&
         (!clr_wr || (clr_idx >= SRC_LIM && clr_idx != ALL_CODE))) |=> $stable(mask_o)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && clr_wr && set_idx == clr_idx && set_idx < SRC_LIM)
            |=> mask_o[$past(set_idx[IDXW-1:0])]); // R7
endmodule

// File: rtl/intm_levels.sv
module intm_levels
    import intm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lvl_wr,
    input  logic [IDXW-1:0]           lvl_sel,
    input  logic [LVLW-1:0]           lvl_data,
    output logic [NSRC-1:0][LVLW-1:0] lvl_o
);
    typedef struct packed {
        logic [NSRC-1:0][LVLW-1:0] lvl;
    } lstate_t;

    lstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lvl_wr)
            st_d.lvl[lvl_sel] = lvl_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    AST_LVL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_wr |=> (lvl_o[$past(lvl_sel)] == $past(lvl_data))); // R8
    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_wr |=> $stable(lvl_o)); // R8
endmodule

// File: rtl/intm_arb.sv
module intm_arb
    import intm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           pend_i,
    input  logic [NSRC-1:0]           mask_i,
    input  logic [NSRC-1:0][LVLW-1:0] lvl_i,
    output logic                      req_valid,
    output logic [IDXW-1:0]           req_vec,
    output logic [LVLW-1:0]           req_lvl
);
    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] vec;
        logic [LVLW-1:0] lvl;
    } ostate_t;

    ostate_t st_d, st_q;
    logic [NSRC-1:0] elig;
    cand_t node [1:2*NSRC-1];

    // heap-ordered tree: leaves at NSRC.., node k merges 2k (lower) and 2k+1
    for (genvar i = 0; i < NSRC; i++) begin : g_leaf
        assign elig[i] = pend_i[i] && !mask_i[i] && (lvl_i[i] != '0);
        assign node[NSRC+i] = '{valid: elig[i], lvl: lvl_i[i], idx: IDXW'(i)};
    end
    for (genvar k = 1; k < NSRC; k++) begin : g_node
        assign node[k] = pick(node[2*k], node[2*k+1]);
    end

    always_comb begin
        st_d = '0;
        if (node[1].valid) begin
            st_d.valid = 1'b1;
            st_d.vec   = node[1].idx;
            st_d.lvl   = node[1].lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign req_valid = st_q.valid;
    assign req_vec   = st_q.vec;
    assign req_lvl   = st_q.lvl;

    // independent flat scan to cross-check the tree result
    logic beaten, tie_lower;
    always_comb begin
        beaten    = 1'b0;
        tie_lower = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && node[1].valid && lvl_i[i] > node[1].lvl)
                beaten = 1'b1;
            if (elig[i] && node[1].valid && lvl_i[i] == node[1].lvl && IDXW'(i) < node[1].idx)
                tie_lower = 1'b1;
        end
    end

    AST_NOT_BEATEN: assert property (@(posedge clk) disable iff (!rst_n)
        !beaten); // R9
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !tie_lower); // R10
    AST_ANY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |=> req_valid); // R9
    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> (!req_valid && req_vec == '0 && req_lvl == '0)); // R11
    AST_LVL_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_lvl != '0)); // R8
endmodule

// File: rtl/intr_mask_ctrl.sv
module intr_mask_ctrl
    import intm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic [CODEW-1:0] set_idx,
    input  logic             clr_wr,
    input  logic [CODEW-1:0] clr_idx,
    input  logic             lvl_wr,
    input  logic [IDXW-1:0]  lvl_sel,
    input  logic [LVLW-1:0]  lvl_data,
    input  logic [NSRC-1:0]  irq_pend,
    output logic             req_valid,
    output logic [IDXW-1:0]  req_vec,
    output logic [LVLW-1:0]  req_lvl
);
    logic [NSRC-1:0]           mask_q;
    logic [NSRC-1:0][LVLW-1:0] lvl_q;

    intm_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_wr  (set_wr),
        .set_idx (set_idx),
        .clr_wr  (clr_wr),
        .clr_idx (clr_idx),
        .mask_o  (mask_q)
    );

    intm_levels u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_wr   (lvl_wr),
        .lvl_sel  (lvl_sel),
        .lvl_data (lvl_data),
        .lvl_o    (lvl_q)
    );

    intm_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (irq_pend),
        .mask_i    (mask_q),
        .lvl_i     (lvl_q),
        .req_valid (req_valid),
        .req_vec   (req_vec),
        .req_lvl   (req_lvl)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !req_valid); // R1
endmodule

// File: tb/sim_intr_mask_ctrl.sv
module sim_intr_mask_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        set_wr = 0, clr_wr = 0, lvl_wr = 0;
    logic [7:0]  set_idx = 0, clr_idx = 0;
    logic [5:0]  lvl_sel = 0;
    logic [2:0]  lvl_data = 0;
    logic [63:0] irq_pend = '1;
    logic        req_valid;
    logic [5:0]  req_vec;
    logic [2:0]  req_lvl;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    intr_mask_ctrl u0 (.*);

    task automatic expect_out(input string r, input bit v, input int vec, input int lvl);
        checks++;
        if (req_valid !== v || req_vec !== 6'(vec) || req_lvl !== 3'(lvl)) begin
            errors++;
            $display("FAIL %s: got valid=%0b vec=%0d lvl=%0d, expected valid=%0b vec=%0d lvl=%0d",
                     r, req_valid, req_vec, req_lvl, v, vec, lvl);
        end
    endtask

    // all drivers start and end at a falling edge
    task automatic wr_set(input logic [7:0] i);
        set_wr = 1; set_idx = i; @(negedge clk); set_wr = 0; @(negedge clk);
    endtask
    task automatic wr_clr(input logic [7:0] i);
        clr_wr = 1; clr_idx = i; @(negedge clk); clr_wr = 0; @(negedge clk);
    endtask
    task automatic wr_both(input logic [7:0] s, input logic [7:0] c);
        set_wr = 1; set_idx = s; clr_wr = 1; clr_idx = c;
        @(negedge clk); set_wr = 0; clr_wr = 0; @(negedge clk);
    endtask
    task automatic wr_lvl(input int s, input int d);
        lvl_wr = 1; lvl_sel = 6'(s); lvl_data = 3'(d);
        @(negedge clk); lvl_wr = 0; @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        expect_out("R1 reset idle with all pending", 0, 0, 0);
        wr_clr(8'hFF);
        expect_out("R1 levels zero after reset", 0, 0, 0);
    endtask

    task automatic t_priority;
        wr_lvl(3, 5); wr_lvl(4, 5);
        expect_out("R10 tie 3 vs 4", 1, 3, 5);
        wr_lvl(40, 6);
        expect_out("R9 higher level wins", 1, 40, 6);
        wr_lvl(20, 6);
        expect_out("R10 tie 20 vs 40", 1, 20, 6);
        wr_set(8'd20);
        expect_out("R2 mask single source", 1, 40, 6);
        wr_set(8'd40);
        expect_out("R2 mask second source", 1, 3, 5);
        wr_clr(8'd20);
        expect_out("R3 unmask single source", 1, 20, 6);
    endtask

    task automatic t_ranges;
        wr_set(8'd84);  // low six bits = 20
        expect_out("R6 set index 84 ignored", 1, 20, 6);
        wr_set(8'd254);
        expect_out("R6 set index 254 ignored", 1, 20, 6);
        wr_set(8'd64);
        expect_out("R6 set index 64 ignored", 1, 20, 6);
        wr_set(8'hFF);
        expect_out("R4 set all masks every source / R11 idle zero", 0, 0, 0);
        wr_clr(8'd100);
        expect_out("R6 clear index 100 ignored", 0, 0, 0);
        wr_clr(8'd200);
        expect_out("R6 clear index 200 ignored", 0, 0, 0);
        wr_clr(8'hFF);
        expect_out("R5 clear all unmasks every source", 1, 20, 6);
    endtask

    task automatic t_same_cycle;
        wr_both(8'd20, 8'd20);
        expect_out("R7 set wins on same source", 1, 40, 6);
        wr_both(8'hFF, 8'd40);
        expect_out("R7 set all wins over clear", 0, 0, 0);
        wr_both(8'd5, 8'd40);
        expect_out("R7 distinct bits both apply", 1, 40, 6);
    endtask

    task automatic t_timing;
        wr_clr(8'hFF);
        expect_out("R12 setup", 1, 20, 6);
        wr_lvl(63, 7);
        expect_out("R12 new level after two edges", 1, 63, 7);
        irq_pend = 64'h8;
        #1 expect_out("R12 output held before edge", 1, 63, 7);
        @(negedge clk);
        expect_out("R12 pending change one edge later", 1, 3, 5);
        irq_pend = '0;
        @(negedge clk);
        expect_out("R11 nothing pending", 0, 0, 0);
        irq_pend = (64'h1 << 41) | (64'h1 << 7);
        @(negedge clk);
        expect_out("R8 level zero sources never requested", 0, 0, 0);
        irq_pend = (64'h1 << 40) | (64'h1 << 41);
        @(negedge clk);
        expect_out("R9 only qualifying source", 1, 40, 6);
        wr_lvl(40, 0);
        expect_out("R8 level cleared to zero", 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_priority();
        t_ranges();
        t_same_cycle();
        t_timing();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule